// File: doc/BRIEF.md
# Markov correlation miss prefetcher

This block watches the global stream of cache-miss block addresses and learns, for each miss address, which addresses tended to miss right after it. The table it keeps approximates a Markov graph in which each state is a miss address. Each state holds at most two successor guesses, ordered by how recently each was seen. Prefetch targets therefore come from address-to-address history and not from any arithmetic pattern such as a stride.

Each valid miss does two things in the same cycle. It trains the entry of the previous miss, recording the current address as a successor of that miss. It also looks up the current address and queues whatever successors are stored for it. Requests leave through a small in-order output queue that a downstream memory scheduler drains at its own pace. When the queue has no room, the request is dropped rather than stalling the miss stream.

Top module: `mkv_prefetch`

## Requirements
- R1: After reset the output queue is empty (`pfValid` low), no table entry is valid and no previous miss is held, so the first miss trains nothing and issues no prefetch.
- R2: Each miss after the first trains the entry of the previous miss address. The entry is selected by address bits [7:0] and tagged with bits [15:8]. A lookup whose tag does not match issues nothing.
- R3: A successor not yet stored becomes the first prediction. The old first prediction moves to the second slot, and the old second prediction is discarded.
- R4: A successor already in the first slot leaves the entry unchanged. A successor already in the second slot is swapped into the first slot. No address is ever stored twice in one entry.
- R5: Training an entry whose tag differs from the previous miss replaces it: new tag, the current address as the only prediction, second slot empty.
- R6: A miss that hits a valid entry queues its first prediction and then its second. Each request is visible on `pfValid`/`pfAddr` from the cycle after the miss. The lookup sees the table as it stood before the same miss's own training.
- R7: The output queue holds 4 requests and hands them out oldest first. `pfAddr` shows the oldest request, and it is removed on a clock edge where `pfValid` and `pfReady` are both high.
- R8: Room in the queue is judged on its occupancy at the start of the cycle, so a removal in the same cycle makes no room. A request that does not fit is dropped, and the first prediction takes priority over the second.
- R9: While `missValid` is low the table, the held previous address and the queue contents are left unchanged, whatever `missAddr` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| missValid | input | 1 | A cache miss is presented this cycle |
| missAddr | input | 16 | Block address of the miss |
| pfReady | input | 1 | Consumer takes the head request this cycle |
| pfValid | output | 1 | Output queue holds at least one request |
| pfAddr | output | 16 | Block address of the oldest queued request |

## Verification
The bench walks a miss sequence that builds, reorders and evicts entries, and drains the queue after every miss so that both the order and the exact number of requests are seen. A design that pushed a new successor in without shifting would lose the older guess. A design that did not swap on a second-slot match would hold the wrong order, or would store one address twice and issue it twice. Aliasing addresses that share an index check that a tag mismatch neither predicts nor merges into the old entry. A deliberately full queue checks that a same-cycle removal makes no room, and that the first prediction is the one kept when only one slot is free; a design that got this wrong would emit the second guess or overrun the queue. Idle cycles with a changing `missAddr` expose a previous-miss register that latches without `missValid`.

// File: rtl/mkv_pkg.sv
package mkv_pkg;

  // Training action for the entry of the previous miss
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,  // successor already first, or nothing to train
    UPD_NEW     = 2'd1,  // allocate or replace the entry
    UPD_PROMOTE = 2'd2,  // second slot matched: swap it to the front
    UPD_SHIFT   = 2'd3   // fresh successor: push into first slot
  } updKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    updKind_t upd;
    logic     push1;
    logic     push2;
    logic     pop;
    logic     latchPrev;
  } ctrlStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic       lkHit;
    logic       lkV1;
    logic       lkV2;
    logic       trHit;
    logic       trM1;
    logic       trM2;
    logic       fifoEmpty;
    logic [1:0] room;      // free slots, clipped to 2
  } dpStatus_t;

endpackage

// File: rtl/mkv_ctrl.sv
module mkv_ctrl
  import mkv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        missValid,
  input  logic        pfReady,
  input  dpStatus_t   stat,
  output ctrlStrobe_t strb
);

  logic prevValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevValid <= 1'b0;
    else if (missValid) prevValid <= 1'b1;
  end

  logic want1, want2;
  assign want1 = missValid && stat.lkHit && stat.lkV1;
  assign want2 = missValid && stat.lkHit && stat.lkV2;

  always_comb begin
    strb = '0;
    strb.latchPrev = missValid;
    strb.pop       = pfReady && !stat.fifoEmpty;
    if (missValid && prevValid) begin
      if (!stat.trHit)    strb.upd = UPD_NEW;
      else if (stat.trM1) strb.upd = UPD_NONE;
      else if (stat.trM2) strb.upd = UPD_PROMOTE;
      else                strb.upd = UPD_SHIFT;
    end
    strb.push1 = want1 && (stat.room != 2'd0);
    strb.push2 = want2 && (want1 ? (stat.room == 2'd2) : (stat.room != 2'd0));
  end

  // R1: nothing is trained before a previous miss exists
  p_first_miss_r1: assert property (@(posedge clk) disable iff (!rstN)
    !prevValid |-> (strb.upd == UPD_NONE));

  // R9: an idle cycle neither trains nor queues
  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !missValid |-> (strb.upd == UPD_NONE && !strb.push1 && !strb.push2));

  // R8: the second guess never takes a slot that the first was denied
  p_first_prio_r8: assert property (@(posedge clk) disable iff (!rstN)
    (want1 && !strb.push1) |-> !strb.push2);

endmodule

// File: rtl/mkv_datapath.sv
module mkv_datapath
  import mkv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter int DEPTH  = 4   // power of two
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] missAddr,
  input  ctrlStrobe_t       strb,
  output dpStatus_t         stat,
  output logic              pfValid,
  output logic [ADDR_W-1:0] pfAddr
);

  localparam int TAG_W   = ADDR_W - IDX_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  // ---------------- correlation table ----------------
  logic              entValid [ENTRIES];
  logic [TAG_W-1:0]  entTag   [ENTRIES];
  logic [ADDR_W-1:0] pred1    [ENTRIES];
  logic [ADDR_W-1:0] pred2    [ENTRIES];
  logic              has1     [ENTRIES];
  logic              has2     [ENTRIES];

  logic [ADDR_W-1:0] prevAddr;

  logic [IDX_W-1:0] lkIdx, trIdx;
  logic [TAG_W-1:0] lkTag, trTag;
  assign lkIdx = missAddr[IDX_W-1:0];
  assign lkTag = missAddr[ADDR_W-1:IDX_W];
  assign trIdx = prevAddr[IDX_W-1:0];
  assign trTag = prevAddr[ADDR_W-1:IDX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevAddr <= '0;
    else if (strb.latchPrev) prevAddr <= missAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) entValid[i] <= 1'b0;
    end else if (strb.upd == UPD_NEW) begin
      entValid[trIdx] <= 1'b1;
      entTag[trIdx]   <= trTag;
    end
  end

  always_ff @(posedge clk) begin
    case (strb.upd)
      UPD_NEW: begin
        pred1[trIdx] <= missAddr;
        has1[trIdx]  <= 1'b1;
        has2[trIdx]  <= 1'b0;
      end
      UPD_PROMOTE: begin
        pred1[trIdx] <= missAddr;
        pred2[trIdx] <= pred1[trIdx];
      end
      UPD_SHIFT: begin
        pred1[trIdx] <= missAddr;
        pred2[trIdx] <= pred1[trIdx];
        has2[trIdx]  <= has1[trIdx];
        has1[trIdx]  <= 1'b1;
      end
      default: ;
    endcase
  end

  // ---------------- output queue ----------------
  logic [ADDR_W-1:0] qMem [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count, free;

  logic [PTR_W-1:0] slot2;
  assign slot2 = strb.push1 ? PTR_W'(tail + PTR_W'(1)) : tail;
  assign free  = CNT_W'(DEPTH) - count;

  always_ff @(posedge clk) begin
    if (strb.push1) qMem[tail]  <= pred1[lkIdx];
    if (strb.push2) qMem[slot2] <= pred2[lkIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      tail  <= PTR_W'(tail + PTR_W'(strb.push1) + PTR_W'(strb.push2));
      head  <= PTR_W'(head + PTR_W'(strb.pop));
      count <= CNT_W'(count + CNT_W'(strb.push1) + CNT_W'(strb.push2) - CNT_W'(strb.pop));
    end
  end

  assign pfValid = (count != '0);
  assign pfAddr  = qMem[head];

  // ---------------- status ----------------
  always_comb begin
    stat.lkHit     = entValid[lkIdx] && (entTag[lkIdx] == lkTag);
    stat.lkV1      = has1[lkIdx];
    stat.lkV2      = has2[lkIdx];
    stat.trHit     = entValid[trIdx] && (entTag[trIdx] == trTag);
    stat.trM1      = has1[trIdx] && (pred1[trIdx] == missAddr);
    stat.trM2      = has2[trIdx] && (pred2[trIdx] == missAddr);
    stat.fifoEmpty = (count == '0);
    stat.room      = (free >= CNT_W'(2)) ? 2'd2 : 2'(free);
  end

  // R7: occupancy never exceeds the queue depth
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R7: nothing is removed from an empty queue
  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |-> !strb.pop);

  // R8: a full queue with no removal stays exactly full
  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(DEPTH) && !strb.pop) |=> (count == CNT_W'(DEPTH)));

  // R9: the held previous miss only moves on a valid miss
  p_prev_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchPrev |=> $stable(prevAddr));

endmodule

// File: rtl/mkv_prefetch.sv
module mkv_prefetch
  import mkv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              pfReady,
  output logic              pfValid,
  output logic [ADDR_W-1:0] pfAddr
);

  ctrlStrobe_t strb;
  dpStatus_t   stat;

  mkv_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .missValid (missValid),
    .pfReady   (pfReady),
    .stat      (stat),
    .strb      (strb)
  );

  mkv_datapath #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .DEPTH  (DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .missAddr (missAddr),
    .strb     (strb),
    .stat     (stat),
    .pfValid  (pfValid),
    .pfAddr   (pfAddr)
  );

endmodule

// File: tb/mkv_prefetch_tb.sv
module mkv_prefetch_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic [15:0] missAddr = '0;
  logic        pfReady = 1'b0;
  logic        pfValid;
  logic [15:0] pfAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  mkv_prefetch u_dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .pfReady(pfReady), .pfValid(pfValid), .pfAddr(pfAddr)
  );

  localparam logic [15:0] A  = 16'h1210;
  localparam logic [15:0] B  = 16'h3320;
  localparam logic [15:0] C  = 16'h4430;
  localparam logic [15:0] D  = 16'h5540;
  localparam logic [15:0] AX = 16'h9910;  // same index as A, other tag
  localparam logic [15:0] E  = 16'h6650;

  typedef struct packed {
    logic [15:0] addr;
    logic [1:0]  n;
    logic [15:0] e1;
    logic [15:0] e2;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{A,  2'd0, 16'h0, 16'h0, 4'd1},  // R1 first miss: nothing
    '{B,  2'd0, 16'h0, 16'h0, 4'd2},  // R2 trains A->B
    '{A,  2'd1, B,     16'h0, 4'd6},  // R6 A predicts B
    '{C,  2'd0, 16'h0, 16'h0, 4'd3},  // R3 A: C,B
    '{A,  2'd2, C,     B,     4'd3},  // R3 order
    '{B,  2'd1, A,     16'h0, 4'd4},  // R4 A: B second -> swap
    '{A,  2'd2, B,     C,     4'd4},  // R4 swapped
    '{B,  2'd1, A,     16'h0, 4'd4},  // R4 B first: unchanged, no duplicate
    '{A,  2'd2, B,     C,     4'd4},  // R4 unchanged
    '{D,  2'd0, 16'h0, 16'h0, 4'd3},  // R3 A: D,B (C dropped)
    '{A,  2'd2, D,     B,     4'd3},  // R3
    '{AX, 2'd0, 16'h0, 16'h0, 4'd2},  // R2 tag mismatch: no prefetch
    '{C,  2'd1, A,     16'h0, 4'd6},  // R6 C predicts A; AX replaces A entry
    '{A,  2'd0, 16'h0, 16'h0, 4'd5},  // R5 A entry evicted
    '{AX, 2'd1, C,     16'h0, 4'd5},  // R5 single prediction
    '{AX, 2'd0, 16'h0, 16'h0, 4'd6},  // R6 lookup before own training
    '{AX, 2'd1, AX,    16'h0, 4'd6}   // R6 self successor learned
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic applyMiss(input logic [15:0] a, input logic rdy);
    missValid = 1'b1; missAddr = a; pfReady = rdy;
    @(posedge clk); @(negedge clk);
    missValid = 1'b0; pfReady = 1'b0;
  endtask

  task automatic popOne();
    pfReady = 1'b1;
    @(posedge clk); @(negedge clk);
    pfReady = 1'b0;
  endtask

  task automatic expectHead(input string tag, input logic [15:0] a);
    chk(tag, {15'd0, pfValid, pfAddr}, {15'd0, 1'b1, a});
    popOne();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pfValid", {31'd0, pfValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {31'd0, pfValid}, 32'd0);

    // Vector table: miss, then drain and count the requests
    for (int i = 0; i < NV; i++) begin
      applyMiss(VECS[i].addr, 1'b0);
      if (VECS[i].n >= 2'd1) expectHead($sformatf("R%0d vec%0d first", VECS[i].req, i), VECS[i].e1);
      if (VECS[i].n == 2'd2) expectHead($sformatf("R%0d vec%0d second", VECS[i].req, i), VECS[i].e2);
      chk($sformatf("R%0d vec%0d count", VECS[i].req, i), {31'd0, pfValid}, 32'd0);
    end

    // R9: idle cycles with a changing address must not move the previous miss
    missAddr = B;
    @(negedge clk);
    missAddr = C;
    @(negedge clk);
    chk("R9 idle no output", {31'd0, pfValid}, 32'd0);
    applyMiss(E, 1'b0);                // trains AX -> E (AX was last miss)
    chk("R9 new addr no prefetch", {31'd0, pfValid}, 32'd0);
    applyMiss(AX, 1'b0);
    expectHead("R9 AX first is E", E);
    expectHead("R9 AX second is AX", AX);
    chk("R9 drained", {31'd0, pfValid}, 32'd0);

    // R8 / R7: fill the queue, check drops and order
    applyMiss(AX, 1'b0);               // queue: E, AX ; AX entry becomes AX, E
    applyMiss(AX, 1'b0);               // queue: E, AX, AX, E (full)
    chk("R7 head oldest", {15'd0, pfValid, pfAddr}, {15'd0, 1'b1, E});
    applyMiss(AX, 1'b1);               // full at cycle start: both dropped; E removed
    applyMiss(AX, 1'b0);               // one slot: only first guess AX kept
    expectHead("R8 drain 1", AX);
    expectHead("R8 drain 2", AX);
    expectHead("R8 drain 3", E);
    expectHead("R8 drain 4 first kept", AX);
    chk("R8 empty after drain", {31'd0, pfValid}, 32'd0);
    popOne();
    chk("R7 pop on empty", {31'd0, pfValid}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule